// File: doc/BRIEF.md
# Multiplexed Character Scan Controller

This block drives a time-multiplexed display of eight 16-segment characters with a decimal point. A free-running clock is divided in two stages: a modulo-64 prescaler, and above it a 3-bit character index that selects which display position is lit. The index is presented as an address to an external six-bit character store. The returned code goes out on a font lookup port. The 17-bit pattern that comes back is captured and driven onto the segment outputs while the matching character-select line is active.

Each 64-clock character slot is split into a lit part and a dark part. During the dark part, the four counts at each end of the slot, every segment and select line is off, so the pattern of one position never shows on its neighbour. The code 100000 marks an empty position and always gives a dark pattern. While a data write is under way, scanning freezes. A standby input forces everything dark, holds both counters at zero and masks an externally supplied full flag. Scanning starts again at the first character once standby is released.

Top module: `char_scan_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, char_sel_o and seg_o are all zero, full_o is 0 and mem_addr_o is 0.
- R2: With no write in progress and standby low, mem_addr_o advances by one every 64 clocks, runs 0,1,...,7, and wraps from 7 to 0.
- R3: At most one bit of char_sel_o is set, and the set bit is bit k when mem_addr_o holds k (bit 0 is the left-most character).
- R4: Within each 64-count slot the outputs are dark for prescaler counts 60..63 and 0..3, each seen one clock later at the ports, so each slot has exactly 56 lit clocks.
- R5: During the lit part of a slot, seg_o carries the font_seg_i value returned for that slot's code, captured at prescaler count 2. Bit 16 is the decimal point.
- R6: A code of 6'b100000 gives seg_o equal to zero whatever font_seg_i returns.
- R7: One clock after standby_i is high, char_sel_o, seg_o and full_o are zero and mem_addr_o is 0.
- R8: After standby_i falls, scanning restarts with mem_addr_o at 0, and the first lit select line is bit 0.
- R9: While write_busy_i is high, the prescaler and character index hold their values, so mem_addr_o, char_sel_o and seg_o stay constant from the second clock of the write on.
- R10: When standby_i is low, full_o equals the value full_in_i had one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| standby_i | input | 1 | Low-power request: blank, clear counters, mask full flag |
| write_busy_i | input | 1 | High while a data write is in progress; freezes scanning |
| full_in_i | input | 1 | Full flag from the entry logic |
| full_o | output | 1 | Full flag, masked in standby, registered |
| mem_addr_o | output | 3 | Character index sent to the character store |
| mem_code_i | input | 6 | Character code read from the store at mem_addr_o |
| font_code_o | output | 6 | Code presented to the font lookup |
| font_seg_i | input | 17 | Segment pattern from the font lookup |
| char_sel_o | output | 8 | One-hot character select, active high |
| seg_o | output | 17 | Segment outputs (16 segments plus decimal point), active high |

## Verification
The hardest cases to reach from the ports are a write or a standby request that lands inside the eight-count dark window, or exactly on the capture count. Then the frozen or cleared prescaler has to resume without letting a stale pattern leak into the next position. The random phase toggles write_busy_i and standby_i in short bursts at arbitrary cycles, so these alignments occur many times. It also rewrites the store and puts the empty code in random positions. A cycle-exact reference model built from the requirements is compared on every cycle. Directed phases measure the slot length, the lit count, the freeze and the restart.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int CODE_BITS = 6;
  localparam logic [CODE_BITS-1:0] EMPTY_CODE = 6'b100000;
endpackage

// File: rtl/csc_prescaler.sv
module csc_prescaler #(
  parameter int PRESCALE = 64,
  localparam int PW = $clog2(PRESCALE)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          run,
  output logic [PW-1:0] count,
  output logic          wrap
);
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  assign wrap = run && (count == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear) count <= '0;
    else if (run) count <= (count == LAST) ? '0 : count + 1'b1;
  end
endmodule

// File: rtl/csc_char_counter.sv
module csc_char_counter #(
  parameter int NUM_CHARS = 8,
  localparam int IW = $clog2(NUM_CHARS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          step,
  output logic [IW-1:0] idx
);
  localparam logic [IW-1:0] LAST = IW'(NUM_CHARS - 1);

  always_ff @(posedge clk) begin
    if (rst || clear) idx <= '0;
    else if (step) idx <= (idx == LAST) ? '0 : idx + 1'b1;
  end
endmodule

// File: rtl/csc_out_stage.sv
module csc_out_stage
  import csc_pkg::*;
#(
  parameter int NUM_CHARS  = 8,
  parameter int PRESCALE   = 64,
  parameter int BLANK_HALF = 4,
  parameter int SEG_W      = 17,
  localparam int PW = $clog2(PRESCALE),
  localparam int IW = $clog2(NUM_CHARS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 standby,
  input  logic [PW-1:0]        pre_cnt,
  input  logic [IW-1:0]        idx,
  input  logic [CODE_BITS-1:0] code,
  input  logic [SEG_W-1:0]     font_seg,
  input  logic                 full_in,
  output logic [NUM_CHARS-1:0] sel_o,
  output logic [SEG_W-1:0]     seg_o,
  output logic                 full_o
);
  localparam logic [PW-1:0] DARK_HI = PW'(PRESCALE - BLANK_HALF);
  localparam logic [PW-1:0] DARK_LO = PW'(BLANK_HALF);
  localparam logic [PW-1:0] GRAB_AT = PW'(BLANK_HALF - 2);

  logic                 dark;
  logic                 grab;
  logic [SEG_W-1:0]     seg_hold;
  logic [NUM_CHARS-1:0] sel_next;

  assign dark = (pre_cnt >= DARK_HI) || (pre_cnt < DARK_LO);
  assign grab = (pre_cnt == GRAB_AT);

  for (genvar i = 0; i < NUM_CHARS; i++) begin : g_sel
    assign sel_next[i] = !dark && (idx == IW'(i));
  end

  always_ff @(posedge clk) begin
    if (rst || standby) seg_hold <= '0;
    else if (grab) seg_hold <= (code == EMPTY_CODE) ? '0 : font_seg;
  end

  always_ff @(posedge clk) begin
    if (rst || standby) begin
      sel_o  <= '0;
      seg_o  <= '0;
      full_o <= 1'b0;
    end else begin
      sel_o  <= sel_next;
      seg_o  <= dark ? '0 : seg_hold;
      full_o <= full_in;
    end
  end
endmodule

// File: rtl/char_scan_ctrl.sv
module char_scan_ctrl
  import csc_pkg::*;
#(
  parameter int NUM_CHARS  = 8,
  parameter int PRESCALE   = 64,
  parameter int BLANK_HALF = 4,
  parameter int SEG_W      = 17,
  localparam int PW = $clog2(PRESCALE),
  localparam int IW = $clog2(NUM_CHARS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 standby_i,
  input  logic                 write_busy_i,
  input  logic                 full_in_i,
  output logic                 full_o,
  output logic [IW-1:0]        mem_addr_o,
  input  logic [CODE_BITS-1:0] mem_code_i,
  output logic [CODE_BITS-1:0] font_code_o,
  input  logic [SEG_W-1:0]     font_seg_i,
  output logic [NUM_CHARS-1:0] char_sel_o,
  output logic [SEG_W-1:0]     seg_o
);
  logic [PW-1:0] pre_cnt;
  logic          pre_wrap;
  logic          run;

  assign run         = !write_busy_i && !standby_i;
  assign font_code_o = mem_code_i;

  csc_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk(clk), .rst(rst), .clear(standby_i), .run(run),
    .count(pre_cnt), .wrap(pre_wrap)
  );

  csc_char_counter #(.NUM_CHARS(NUM_CHARS)) u_idx (
    .clk(clk), .rst(rst), .clear(standby_i), .step(pre_wrap),
    .idx(mem_addr_o)
  );

  csc_out_stage #(
    .NUM_CHARS(NUM_CHARS), .PRESCALE(PRESCALE),
    .BLANK_HALF(BLANK_HALF), .SEG_W(SEG_W)
  ) u_out (
    .clk(clk), .rst(rst), .standby(standby_i), .pre_cnt(pre_cnt),
    .idx(mem_addr_o), .code(mem_code_i), .font_seg(font_seg_i),
    .full_in(full_in_i), .sel_o(char_sel_o), .seg_o(seg_o),
    .full_o(full_o)
  );
endmodule

// File: rtl/char_scan_ctrl_chk.sv
module char_scan_ctrl_chk #(
  parameter int NUM_CHARS = 8,
  parameter int SEG_W     = 17,
  localparam int IW = $clog2(NUM_CHARS)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 standby_i,
  input logic                 write_busy_i,
  input logic                 full_in_i,
  input logic                 full_o,
  input logic [IW-1:0]        mem_addr_o,
  input logic [NUM_CHARS-1:0] char_sel_o,
  input logic [SEG_W-1:0]     seg_o
);
  a_r3_sel_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(char_sel_o));

  a_r4_seg_needs_sel: assert property (@(posedge clk) disable iff (rst)
    (seg_o != '0) |-> (char_sel_o != '0));

  a_r7_standby_dark: assert property (@(posedge clk) disable iff (rst)
    standby_i |=> (char_sel_o == '0 && seg_o == '0 && !full_o && mem_addr_o == '0));

  a_r9_busy_holds_addr: assert property (@(posedge clk) disable iff (rst)
    (write_busy_i && !standby_i) |=> $stable(mem_addr_o));

  a_r2_addr_steps_by_one: assert property (@(posedge clk) disable iff (rst)
    (mem_addr_o != $past(mem_addr_o)) |->
      (mem_addr_o == IW'($past(mem_addr_o) + 1'b1) || mem_addr_o == '0));

  a_r10_full_follows: assert property (@(posedge clk) disable iff (rst)
    !standby_i |=> (full_o == $past(full_in_i)));
endmodule

bind char_scan_ctrl char_scan_ctrl_chk #(.NUM_CHARS(NUM_CHARS), .SEG_W(SEG_W)) u_chk (
  .clk(clk), .rst(rst), .standby_i(standby_i), .write_busy_i(write_busy_i),
  .full_in_i(full_in_i), .full_o(full_o), .mem_addr_o(mem_addr_o),
  .char_sel_o(char_sel_o), .seg_o(seg_o)
);

// File: tb/char_scan_ctrl_tb.sv
module char_scan_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        standby = 1'b0;
  logic        busy = 1'b0;
  logic        full_in = 1'b0;
  logic        full_o;
  logic [2:0]  addr;
  logic [5:0]  code;
  logic [5:0]  font_code;
  logic [16:0] font_seg;
  logic [7:0]  sel;
  logic [16:0] seg;

  logic [5:0] mem [8];

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  function automatic logic [16:0] font_of(logic [5:0] c);
    return {c[0], c, ~c, c[5:2]};
  endfunction

  assign code     = mem[addr];
  assign font_seg = font_of(font_code);

  always #(CLK_PERIOD/2) clk = ~clk;

  char_scan_ctrl u_dut (
    .clk(clk), .rst(rst), .standby_i(standby), .write_busy_i(busy),
    .full_in_i(full_in), .full_o(full_o), .mem_addr_o(addr),
    .mem_code_i(code), .font_code_o(font_code), .font_seg_i(font_seg),
    .char_sel_o(sel), .seg_o(seg)
  );

  // Reference model derived from the requirements
  int          m_pre = 0;
  int          m_idx = 0;
  logic [16:0] m_hold = '0;
  logic [7:0]  e_sel = '0;
  logic [16:0] e_seg = '0;
  logic        e_full = 1'b0;

  function automatic bit dark_at(int p);
    return (p >= 60) || (p < 4);
  endfunction

  always @(posedge clk) begin
    if (rst || standby) begin
      m_pre <= 0; m_idx <= 0; m_hold <= '0;
      e_sel <= '0; e_seg <= '0; e_full <= 1'b0;
    end else begin
      e_sel  <= dark_at(m_pre) ? 8'h00 : 8'(1 << m_idx);
      e_seg  <= dark_at(m_pre) ? 17'h0 : m_hold;
      e_full <= full_in;
      if (m_pre == 2) m_hold <= (mem[m_idx] == 6'b100000) ? 17'h0 : font_of(mem[m_idx]);
      if (!busy) begin
        m_pre <= (m_pre == 63) ? 0 : m_pre + 1;
        if (m_pre == 63) m_idx <= (m_idx + 1) % 8;
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      check("R3 select", 32'(sel), 32'(e_sel));
      check("R5 segments", 32'(seg), 32'(e_seg));
      check("R10 full", 32'(full_o), 32'(e_full));
      check("R2 address", 32'(addr), 32'(m_idx));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog expired actual %0d expected <= %0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    int t0;
    int lit;
    logic [7:0]  h_sel;
    logic [16:0] h_seg;
    logic [2:0]  h_addr;
    void'($urandom(32'h5EED_0077));
    for (int i = 0; i < 8; i++) mem[i] = 6'(i + 1);
    mem[3] = 6'b100000;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 sel in reset", 32'(sel), 0);
    check("R1 seg in reset", 32'(seg), 0);
    check("R1 full in reset", 32'(full_o), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 addr after reset", 32'(addr), 0);
    check("R1 sel after reset", 32'(sel), 0);
    cmp_on = 1'b1;

    // R2: slot length 64 clocks
    while (addr != 3'd1) @(negedge clk);
    t0 = cyc;
    while (addr != 3'd2) @(negedge clk);
    check("R2 slot length", 32'(cyc - t0), 64);

    // R4: 56 lit clocks per slot
    lit = 0;
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      if (sel != 8'h00) lit++;
    end
    check("R4 lit clocks per slot", 32'(lit), 56);

    // R6: empty code at position 3 stays dark
    while (sel != 8'b0000_1000) @(negedge clk);
    check("R6 empty code dark", 32'(seg), 0);

    // R2: wrap from 7 to 0
    while (addr != 3'd7) @(negedge clk);
    while (addr == 3'd7) @(negedge clk);
    check("R2 wrap to zero", 32'(addr), 0);

    // R9: freeze during a write
    repeat (10) @(negedge clk);
    busy = 1'b1;
    repeat (2) @(negedge clk);
    h_sel = sel; h_seg = seg; h_addr = addr;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (k % 25 == 0) begin
        check("R9 sel held", 32'(sel), 32'(h_sel));
        check("R9 seg held", 32'(seg), 32'(h_seg));
        check("R9 addr held", 32'(addr), 32'(h_addr));
      end
    end
    busy = 1'b0;

    // R7 and R8: standby then restart
    while (addr != 3'd5) @(negedge clk);
    full_in = 1'b1;
    standby = 1'b1;
    @(negedge clk);
    check("R7 sel dark", 32'(sel), 0);
    check("R7 seg dark", 32'(seg), 0);
    check("R7 full masked", 32'(full_o), 0);
    check("R7 addr cleared", 32'(addr), 0);
    repeat (20) @(negedge clk);
    standby = 1'b0;
    @(negedge clk);
    check("R8 restart addr", 32'(addr), 0);
    while (sel == 8'h00) @(negedge clk);
    check("R8 first lit char", 32'(sel), 1);
    check("R10 full passes", 32'(full_o), 1);

    // Random phase
    for (int n = 0; n < 12000; n++) begin
      @(negedge clk);
      full_in = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 99) < 3) mem[$urandom_range(0, 7)] =
          ($urandom_range(0, 3) == 0) ? 6'b100000 : 6'($urandom);
      if (busy) busy = ($urandom_range(0, 9) != 0);
      else      busy = ($urandom_range(0, 99) < 2);
      if (standby) standby = ($urandom_range(0, 4) != 0);
      else         standby = ($urandom_range(0, 999) < 3);
    end
    busy = 1'b0; standby = 1'b0;
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule